// File: doc/BRIEF.md
# I2C Target Configuration Register Bank

This block is an I2C target that owns eight 8-bit configuration registers and one read-only status byte. SCL and SDA are oversampled by the fast system clock; the block finds START and STOP conditions, matches its 7-bit device address, acknowledges by pulling SDA low through an open-drain enable, and then takes a subaddress byte followed by any number of data bytes. All register contents are presented continuously as a flat parallel output so that surrounding logic can use them directly.

A write transfer picks a register with the subaddress. Subaddresses 00h-07h step the register pointer after every data byte, so consecutive registers can be filled in one transfer. Subaddresses F0h-F7h pick the same registers but keep the pointer fixed, so repeated data bytes keep landing in one register. A read transfer has no subaddress phase: it returns the status byte, whose top bit is a power-on flag that reset sets and software clears through register 7.

Top module: `i2cRegBank`

## Requirements
- R1: After reset, register 5 holds 1Fh, register 6 holds 60h, all other registers hold 00h, the power-on flag is 1 and sdaOe is 0.
- R2: An address byte of 34h (device address 0011010, R/W bit 0) is acknowledged; an address byte with any other device address is not acknowledged and the bytes after it until the next START change no register.
- R3: Register i appears on regFlat bits 8*i+7 down to 8*i. With a subaddress in 00h-07h, the first data byte goes to the register given by the low three subaddress bits and the pointer advances by one after each data byte.
- R4: With auto-increment on, the pointer wraps from register 7 to register 0.
- R5: With a subaddress in F0h-F7h (11110xxx), every data byte of the transfer overwrites the register given by the low three bits and the pointer does not move.
- R6: A subaddress outside 00h-07h and F0h-F7h is not acknowledged, and the data bytes after it are neither acknowledged nor written until the next STOP or START.
- R7: An address byte of 35h is acknowledged and the target then sends the status byte MSB first: bit 7 is the power-on flag, bits 6..0 are 0. The byte is sent again for as long as the controller acknowledges.
- R8: Writing a byte with bit 7 set to register 7 clears the power-on flag; bit 7 of register 7 always reads 0 on regFlat.
- R9: A START or STOP arriving in the middle of a byte abandons that byte without a register write; a following transfer works normally.
- R10: Each accepted data byte is acknowledged, and sdaOe only changes while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low asynchronous-free synchronous reset |
| sclIn | input | 1 | SCL line level |
| sdaIn | input | 1 | SDA line level |
| sdaOe | output | 1 | 1 pulls SDA low (open-drain enable) |
| regFlat | output | 64 | All eight registers, register i at bits 8*i+7:8*i |
| porFlag | output | 1 | Power-on flag |

## Verification
The register write and the pointer step happen in the same clock, and on register 7 the write, the flag clear and the bit-7 masking all coincide as well. The bench provokes this with hold-mode and increment-mode bursts that end on register 7 (including a byte with bit 7 set followed by another write to the same register), and with increment bursts that cross from 7 to 0. A behavioural model of the registers and flag, updated per accepted byte, is compared with regFlat and porFlag on every clock while the bus is idle, and the status byte read afterwards must carry the cleared flag.

// File: rtl/i2cRegBankPkg.sv
package i2cRegBankPkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_SUB,
    ST_WDATA,
    ST_ACKWAIT,
    ST_ACKHOLD,
    ST_RDATA,
    ST_RACK,
    ST_SKIP
  } ctrlState_t;

  typedef struct packed {
    logic              subLoad;
    logic              dataWrite;
    logic [BYTE_W-1:0] rxByte;
  } bankStrobe_t;
endpackage

// File: rtl/i2cBusCtrl.sv
module i2cBusCtrl
  import i2cRegBankPkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h1A,
  parameter int         PTR_W       = 3,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [BYTE_W-1:0] statusByte,
  output bankStrobe_t       strb,
  output logic              sdaOe
);
  localparam logic [BYTE_W-1:0] HOLD_BASE = 8'hF0;
  localparam int                PRE_W     = BYTE_W - PTR_W;

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclS, sdaS, sclD, sdaD;
  logic sclRise, sclFall, startCond, stopCond;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclD    <= sclS;
      sdaD    <= sdaS;
    end
  end

  assign sclS      = sclSync[SYNC_STAGES-1];
  assign sdaS      = sdaSync[SYNC_STAGES-1];
  assign sclRise   = sclS & ~sclD;
  assign sclFall   = ~sclS & sclD;
  assign startCond = sclS & sclD & sdaD & ~sdaS;
  assign stopCond  = sclS & sclD & ~sdaD & sdaS;

  ctrlState_t        state, afterAck;
  logic [3:0]        bitCnt;
  logic [BYTE_W-1:0] rxShift, txShift;
  logic [BYTE_W-1:0] rxNext;
  logic              ctrlAck;
  logic              subValid;

  assign rxNext   = {rxShift[BYTE_W-2:0], sdaS};
  assign subValid = (rxNext[BYTE_W-1:PTR_W] == '0) ||
                    (rxNext[BYTE_W-1:PTR_W] == HOLD_BASE[BYTE_W-1:PTR_W]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      afterAck <= ST_IDLE;
      bitCnt   <= '0;
      rxShift  <= '0;
      txShift  <= '0;
      ctrlAck  <= 1'b0;
      sdaOe    <= 1'b0;
      strb     <= '0;
    end else begin
      strb <= '0;
      if (startCond) begin
        state  <= ST_ADDR;
        bitCnt <= '0;
        sdaOe  <= 1'b0;
      end else if (stopCond) begin
        state <= ST_IDLE;
        sdaOe <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_SUB, ST_WDATA: begin
            if (sclRise) begin
              rxShift <= rxNext;
              bitCnt  <= bitCnt + 4'd1;
              if (bitCnt == 4'd7) begin
                bitCnt <= '0;
                if (state == ST_ADDR) begin
                  if (rxNext[BYTE_W-1:1] == DEV_ADDR) begin
                    state    <= ST_ACKWAIT;
                    afterAck <= rxNext[0] ? ST_RDATA : ST_SUB;
                  end else begin
                    state <= ST_IDLE;
                  end
                end else if (state == ST_SUB) begin
                  if (subValid) begin
                    strb.subLoad <= 1'b1;
                    strb.rxByte  <= rxNext;
                    state        <= ST_ACKWAIT;
                    afterAck     <= ST_WDATA;
                  end else begin
                    state <= ST_SKIP;
                  end
                end else begin
                  strb.dataWrite <= 1'b1;
                  strb.rxByte    <= rxNext;
                  state          <= ST_ACKWAIT;
                  afterAck       <= ST_WDATA;
                end
              end
            end
          end
          ST_ACKWAIT: begin
            if (sclFall) begin
              sdaOe <= 1'b1;
              state <= ST_ACKHOLD;
            end
          end
          ST_ACKHOLD: begin
            if (sclFall) begin
              state  <= afterAck;
              bitCnt <= '0;
              if (afterAck == ST_RDATA) begin
                sdaOe   <= ~statusByte[BYTE_W-1];
                txShift <= {statusByte[BYTE_W-2:0], 1'b0};
              end else begin
                sdaOe <= 1'b0;
              end
            end
          end
          ST_RDATA: begin
            if (sclRise) begin
              bitCnt <= bitCnt + 4'd1;
            end else if (sclFall) begin
              if (bitCnt == 4'd8) begin
                sdaOe  <= 1'b0;
                bitCnt <= '0;
                state  <= ST_RACK;
              end else begin
                sdaOe   <= ~txShift[BYTE_W-1];
                txShift <= {txShift[BYTE_W-2:0], 1'b0};
              end
            end
          end
          ST_RACK: begin
            if (sclRise) begin
              ctrlAck <= ~sdaS;
            end else if (sclFall) begin
              if (ctrlAck) begin
                state   <= ST_RDATA;
                bitCnt  <= '0;
                sdaOe   <= ~statusByte[BYTE_W-1];
                txShift <= {statusByte[BYTE_W-2:0], 1'b0};
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2cRegData.sv
module i2cRegData
  import i2cRegBankPkg::*;
#(
  parameter int                            REG_COUNT    = 8,
  parameter logic [REG_COUNT*BYTE_W-1:0]   RESET_VALUES = '0,
  parameter int                            FLAG_REG     = 7,
  parameter int                            FLAG_BIT     = 7
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  bankStrobe_t                   strb,
  output logic [REG_COUNT*BYTE_W-1:0]   regFlat,
  output logic                          porFlag,
  output logic [BYTE_W-1:0]             statusByte
);
  localparam int                PTR_W     = $clog2(REG_COUNT);
  localparam logic [BYTE_W-1:0] FLAG_MASK = BYTE_W'(1) << FLAG_BIT;

  logic [PTR_W-1:0] ptr;
  logic             incOn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr   <= '0;
      incOn <= 1'b1;
    end else if (strb.subLoad) begin
      ptr   <= strb.rxByte[PTR_W-1:0];
      incOn <= ~strb.rxByte[BYTE_W-1];
    end else if (strb.dataWrite && incOn) begin
      ptr <= ptr + 1'b1;
    end
  end

  for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
    logic [BYTE_W-1:0] regQ;
    logic [BYTE_W-1:0] wrVal;
    if (g == FLAG_REG) begin : g_masked
      assign wrVal = strb.rxByte & ~FLAG_MASK;
    end else begin : g_plain
      assign wrVal = strb.rxByte;
    end
    always_ff @(posedge clk) begin
      if (!rstN) begin
        regQ <= RESET_VALUES[g*BYTE_W +: BYTE_W];
      end else if (strb.dataWrite && (ptr == PTR_W'(g))) begin
        regQ <= wrVal;
      end
    end
    assign regFlat[g*BYTE_W +: BYTE_W] = regQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      porFlag <= 1'b1;
    end else if (strb.dataWrite && (ptr == PTR_W'(FLAG_REG)) && strb.rxByte[FLAG_BIT]) begin
      porFlag <= 1'b0;
    end
  end

  assign statusByte = {porFlag, {(BYTE_W-1){1'b0}}};
endmodule

// File: rtl/i2cRegBank.sv
module i2cRegBank
  import i2cRegBankPkg::*;
#(
  parameter int                          REG_COUNT    = 8,
  parameter logic [6:0]                  DEV_ADDR     = 7'h1A,
  parameter logic [REG_COUNT*BYTE_W-1:0] RESET_VALUES = 64'h0060_1F00_0000_0000
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        sclIn,
  input  logic                        sdaIn,
  output logic                        sdaOe,
  output logic [REG_COUNT*BYTE_W-1:0] regFlat,
  output logic                        porFlag
);
  localparam int PTR_W = $clog2(REG_COUNT);

  bankStrobe_t       strb;
  logic [BYTE_W-1:0] statusByte;

  i2cBusCtrl #(
    .DEV_ADDR   (DEV_ADDR),
    .PTR_W      (PTR_W),
    .SYNC_STAGES(2)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .statusByte(statusByte),
    .strb      (strb),
    .sdaOe     (sdaOe)
  );

  i2cRegData #(
    .REG_COUNT   (REG_COUNT),
    .RESET_VALUES(RESET_VALUES),
    .FLAG_REG    (REG_COUNT-1),
    .FLAG_BIT    (BYTE_W-1)
  ) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .regFlat   (regFlat),
    .porFlag   (porFlag),
    .statusByte(statusByte)
  );
endmodule

// File: rtl/i2cRegBankChk.sv
module i2cRegBankChk #(
  parameter int REG_COUNT = 8,
  parameter int PTR_W     = 3
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   sclIn,
  input logic                   sdaOe,
  input logic [REG_COUNT*8-1:0] regFlat,
  input logic                   porFlag,
  input logic                   dataWrite,
  input logic                   incOn,
  input logic [PTR_W-1:0]       ptr
);
  // R1 / R8: once out of reset the power-on flag can only be cleared
  p_flag_never_sets_r8: assert property (@(posedge clk) disable iff (!rstN)
    !$rose(porFlag));

  // R3 / R4: an increment-mode write steps the pointer, wrapping at the top
  p_ptr_steps_r3: assert property (@(posedge clk) disable iff (!rstN)
    (dataWrite && incOn) |=> (ptr == PTR_W'($past(ptr) + 1'b1)));

  // R5: a hold-mode write leaves the pointer alone
  p_ptr_holds_r5: assert property (@(posedge clk) disable iff (!rstN)
    (dataWrite && !incOn) |=> $stable(ptr));

  // R10: the open-drain enable only moves while SCL is low
  p_sda_moves_low_r10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclIn);

  // R3: register contents change only during the SCL-high half of a data bit
  p_write_in_high_r3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(regFlat) |-> sclIn);
endmodule

bind i2cRegBank i2cRegBankChk #(
  .REG_COUNT(REG_COUNT),
  .PTR_W    (PTR_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .sclIn    (sclIn),
  .sdaOe    (sdaOe),
  .regFlat  (regFlat),
  .porFlag  (porFlag),
  .dataWrite(strb.dataWrite),
  .incOn    (u_data.incOn),
  .ptr      (u_data.ptr)
);

// File: tb/i2cRegBank_bench.sv
module i2cRegBank_bench;
  localparam int Q = 32;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rstN   = 1'b0;
  logic        sclDrv = 1'b1;
  logic        mSda   = 1'b1;
  logic        sdaOe;
  logic [63:0] regFlat;
  logic        porFlag;
  logic        sdaBus;

  assign sdaBus = mSda & ~sdaOe;

  i2cRegBank u_i2cRegBank (
    .clk    (clk),
    .rstN   (rstN),
    .sclIn  (sclDrv),
    .sdaIn  (sdaBus),
    .sdaOe  (sdaOe),
    .regFlat(regFlat),
    .porFlag(porFlag)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  bit busIdle = 0;
  int idleAge = 0;
  logic [7:0] mReg[8];
  logic       mPor;

  function automatic logic [63:0] modelFlat();
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[8*i +: 8] = mReg[i];
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // model of one accepted data byte
  task automatic mWrite(input int idx, input logic [7:0] v);
    if (idx == 7) begin
      if (v[7]) mPor = 1'b0;
      mReg[7] = v & 8'h7F;
    end else begin
      mReg[idx] = v;
    end
  endtask

  // per-clock comparison against the model while the bus rests
  always @(negedge clk) begin
    if (busIdle && !finished) begin
      idleAge++;
      if (idleAge >= 4) begin
        check(regFlat == modelFlat(), "R3 model registers", regFlat, modelFlat());
        check(porFlag == mPor, "R8 model flag", 64'(porFlag), 64'(mPor));
        check(sdaOe == 1'b0, "R10 idle release", 64'(sdaOe), 64'd0);
      end
    end else begin
      idleAge = 0;
    end
  end

  task automatic waitQ(input int n);
    repeat (n*Q) @(negedge clk);
  endtask

  task automatic busStart();
    busIdle = 0;
    mSda = 1'b1;   waitQ(1);
    sclDrv = 1'b1; waitQ(1);
    mSda = 1'b0;   waitQ(1);
    sclDrv = 1'b0; waitQ(1);
  endtask

  task automatic busStop();
    mSda = 1'b0;   waitQ(1);
    sclDrv = 1'b1; waitQ(1);
    mSda = 1'b1;   waitQ(1);
    busIdle = 1;
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      mSda = b[i];   waitQ(1);
      sclDrv = 1'b1; waitQ(2);
      sclDrv = 1'b0; waitQ(1);
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    sendBits(b, 8);
    mSda = 1'b1;   waitQ(1);
    sclDrv = 1'b1; waitQ(1);
    acked = ~sdaBus;
    waitQ(1);
    sclDrv = 1'b0; waitQ(1);
  endtask

  task automatic readByte(input bit giveAck, output logic [7:0] b);
    mSda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitQ(1);
      sclDrv = 1'b1; waitQ(1);
      b[i] = sdaBus;
      waitQ(1);
      sclDrv = 1'b0;
    end
    waitQ(1);
    mSda = giveAck ? 1'b0 : 1'b1; waitQ(1);
    sclDrv = 1'b1; waitQ(2);
    sclDrv = 1'b0; waitQ(1);
    mSda = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit a;
    logic [7:0] rb;
    for (int i = 0; i < 8; i++) mReg[i] = 8'h00;
    mReg[5] = 8'h1F;
    mReg[6] = 8'h60;
    mPor = 1'b1;

    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(regFlat == 64'h0060_1F00_0000_0000, "R1 reset registers", regFlat, 64'h0060_1F00_0000_0000);
    check(porFlag == 1'b1, "R1 reset flag", 64'(porFlag), 64'd1);
    check(sdaOe == 1'b0, "R1 reset sda", 64'(sdaOe), 64'd0);
    busIdle = 1;
    waitQ(1);

    // R2 R3 R10: increment burst from register 0
    busStart();
    sendByte(8'h34, a); check(a, "R2 write address ack", 64'(a), 64'd1);
    sendByte(8'h00, a); check(a, "R3 subaddress ack", 64'(a), 64'd1);
    sendByte(8'h11, a); check(a, "R10 data ack", 64'(a), 64'd1);
    sendByte(8'h22, a); check(a, "R10 data ack", 64'(a), 64'd1);
    sendByte(8'h33, a); check(a, "R10 data ack", 64'(a), 64'd1);
    mWrite(0, 8'h11); mWrite(1, 8'h22); mWrite(2, 8'h33);
    busStop(); waitQ(1);
    check(regFlat[23:0] == 24'h332211, "R3 increment burst", 64'(regFlat[23:0]), 64'h332211);

    // R4: wrap from 7 to 0
    busStart();
    sendByte(8'h34, a); sendByte(8'h06, a);
    sendByte(8'h66, a); sendByte(8'h77, a); sendByte(8'h88, a);
    mWrite(6, 8'h66); mWrite(7, 8'h77); mWrite(0, 8'h88);
    busStop(); waitQ(1);
    check(regFlat[7:0] == 8'h88, "R4 pointer wrap", 64'(regFlat[7:0]), 64'h88);

    // R5: hold mode
    busStart();
    sendByte(8'h34, a); sendByte(8'hF4, a); check(a, "R5 hold subaddress ack", 64'(a), 64'd1);
    sendByte(8'h01, a); sendByte(8'h02, a); sendByte(8'h03, a);
    mWrite(4, 8'h01); mWrite(4, 8'h02); mWrite(4, 8'h03);
    busStop(); waitQ(1);
    check(regFlat[47:32] == 16'h1F03, "R5 hold burst", 64'(regFlat[47:32]), 64'h1F03);

    // R2: foreign address
    busStart();
    sendByte(8'h36, a); check(!a, "R2 foreign address nack", 64'(a), 64'd0);
    sendByte(8'h00, a); check(!a, "R2 ignored byte nack", 64'(a), 64'd0);
    sendByte(8'h5A, a);
    busStop(); waitQ(1);
    check(regFlat[7:0] == 8'h88, "R2 foreign write ignored", 64'(regFlat[7:0]), 64'h88);

    // R6: invalid subaddresses
    busStart();
    sendByte(8'h34, a);
    sendByte(8'h08, a); check(!a, "R6 subaddress 08 nack", 64'(a), 64'd0);
    sendByte(8'h99, a); check(!a, "R6 data after bad sub nack", 64'(a), 64'd0);
    busStop();
    busStart();
    sendByte(8'h34, a);
    sendByte(8'h80, a); check(!a, "R6 subaddress 80 nack", 64'(a), 64'd0);
    sendByte(8'h44, a);
    busStop(); waitQ(1);
    check(regFlat == modelFlat(), "R6 registers unchanged", regFlat, modelFlat());

    // R7: status reads
    busStart();
    sendByte(8'h35, a); check(a, "R7 read address ack", 64'(a), 64'd1);
    readByte(1'b0, rb); check(rb == 8'h80, "R7 status byte", 64'(rb), 64'h80);
    busStop();
    busStart();
    sendByte(8'h35, a);
    readByte(1'b1, rb); check(rb == 8'h80, "R7 first of two", 64'(rb), 64'h80);
    readByte(1'b0, rb); check(rb == 8'h80, "R7 second of two", 64'(rb), 64'h80);
    busStop();

    // R8 with R5: flag clear and masked bit on register 7
    busStart();
    sendByte(8'h34, a); sendByte(8'hF7, a);
    sendByte(8'hC5, a); sendByte(8'h81, a);
    mWrite(7, 8'hC5); mWrite(7, 8'h81);
    busStop(); waitQ(1);
    check(regFlat[63:56] == 8'h01, "R8 bit 7 masked", 64'(regFlat[63:56]), 64'h01);
    check(porFlag == 1'b0, "R8 flag cleared", 64'(porFlag), 64'd0);
    busStart();
    sendByte(8'h35, a);
    readByte(1'b0, rb); check(rb == 8'h00, "R8 status after clear", 64'(rb), 64'h00);
    busStop();

    // R9: repeated START inside a data byte
    busStart();
    sendByte(8'h34, a); sendByte(8'h02, a);
    sendBits(8'hF0, 4);
    busStart();
    sendByte(8'h34, a); check(a, "R9 address after abort", 64'(a), 64'd1);
    sendByte(8'h02, a); sendByte(8'hAA, a);
    mWrite(2, 8'hAA);
    busStop(); waitQ(1);
    check(regFlat[23:16] == 8'hAA, "R9 write after restart", 64'(regFlat[23:16]), 64'hAA);

    // R9: STOP inside a data byte
    busStart();
    sendByte(8'h34, a); sendByte(8'h03, a);
    sendBits(8'hE7, 4);
    busStop(); waitQ(1);
    check(regFlat[31:24] == 8'h00, "R9 stop abandons byte", 64'(regFlat[31:24]), 64'h00);

    // R9: START inside the address byte
    busStart();
    sendBits(8'h34, 3);
    busStart();
    sendByte(8'h34, a); sendByte(8'h01, a); sendByte(8'h5C, a);
    check(a, "R9 data ack after address abort", 64'(a), 64'd1);
    mWrite(1, 8'h5C);
    busStop(); waitQ(1);
    check(regFlat[15:8] == 8'h5C, "R9 write after address abort", 64'(regFlat[15:8]), 64'h5C);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule